// File: doc/BRIEF.md
# Maskable Interrupt Controller with Selectable Output Modes

This block collects one-cycle event pulses from the surrounding protocol logic. Typical sources are end of message, time tag rollover and error conditions. Each event sets a bit in a 16-bit status register. A mask register decides which pending conditions may raise the single interrupt line `intOut`.

A configuration register selects two things:

- **Status update policy.** In standard updating, only enabled sources latch a status bit. In enhanced updating, every source latches its bit whatever the mask holds.
- **Output shape.** The line can be a fixed-width pulse for each new enabled event. It can be a level held until a software clear strobe. It can also be a level dropped automatically when the host reads the status register.

The host reaches the registers through a simple read/write port and a separate clear strobe.

Top module: `irq_hub`

## Requirements
- R1: After reset the status register and the mask register read 0x0000, the configuration register reads 0x0001 (sticky level, standard updating), and `intOut` is low.
- R2: Register selects are status = 0, mask = 1, configuration = 2, and select 3 reads zero. The mask register holds all 16 written bits. The configuration register keeps `wrData[2:0]` and reads zero above bit 2. A write to the status select changes nothing. `rdData` shows the selected register combinationally in the same cycle.
- R3: With configuration bit 2 clear (standard updating), an event on source k sets status bit k at the next clock edge only if mask bit k is 1. Set bits accumulate until cleared.
- R4: With configuration bit 2 set (enhanced updating), an event on source k sets status bit k at the next clock edge whatever mask bit k holds.
- R5: In the two level modes, `intOut` is high exactly when some status bit has its mask bit set. An enhanced-mode bit latched while masked raises `intOut` once its mask bit is later written to 1.
- R6: With configuration bits [1:0] = 0 (pulse mode), an event whose mask bit is 1 drives `intOut` high for exactly 4 cycles, starting the cycle after the event. A new enabled event restarts the 4-cycle count. Masked events give no pulse, even under enhanced updating.
- R7: With configuration bits [1:0] = 1 (or the spare code 3), `intOut` stays high across status reads and is dropped only by the software clear strobe.
- R8: With configuration bits [1:0] = 2, a read of the status select clears the status register at the end of the read cycle, so `intOut` falls in the next cycle.
- R9: An event arriving in the same cycle as a clear (read-triggered or strobe) leaves its status bit set after that edge.
- R10: A one-cycle `swClear` empties the status register in every mode and drops a level-mode `intOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 16 | One-cycle event pulses, one bit per source |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (triggers clear-on-read) |
| regAddr | input | 2 | Register select |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected register |
| swClear | input | 1 | Software clear of the status register |
| intOut | output | 1 | Interrupt request line |

## Verification
**Sweep over sources, mask polarity and update policy.** Every source is fired alone, in both update policies, once with only its own mask bit set and once with every other mask bit set. This separates a per-bit masking fault from a wrong bit index and from policy confusion.

**Pulse-mode sequences.** An isolated event, a retrigger in mid-pulse and a masked event measure the pulse width, the reload rule and the gating.

**Level-mode sequences.** Reads, clear strobes and events landing on the same edge as a clear tell the two level modes apart and prove that events win over clears.

**Register access.** Writes to the status select and the spare select confirm that the register decoding keeps them inert.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [1:0] {
    MODE_PULSE    = 2'd0,
    MODE_LVL_SW   = 2'd1,
    MODE_LVL_AUTO = 2'd2,
    MODE_LVL_ALT  = 2'd3
  } intMode_e;

  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADR_STATUS = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_MASK   = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_CFG    = 2'd2;

  localparam int CFG_W = 3;
  localparam logic [CFG_W-1:0] CFG_RESET = 3'b001;

  typedef struct packed {
    logic loadMask;
    logic loadCfg;
    logic clearStatus;
  } hubStrobe_t;

endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  swClear,
  input  intMode_e              cfgMode,
  input  logic                  newEnabled,
  input  logic                  pendingEnabled,
  output hubStrobe_t            strobe,
  output logic                  intOut
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             statusRead;
  logic [CNT_W-1:0] pulseCnt;

  assign statusRead = rdEn && (regAddr == ADR_STATUS);

  // Host access decoding into datapath strobes
  always_comb begin
    strobe.loadMask    = wrEn && (regAddr == ADR_MASK);
    strobe.loadCfg     = wrEn && (regAddr == ADR_CFG);
    strobe.clearStatus = swClear || (statusRead && (cfgMode == MODE_LVL_AUTO));
  end

  // Pulse timer: reloads on every new enabled event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pulseCnt <= '0;
    else if (newEnabled)
      pulseCnt <= CNT_LOAD;
    else if (pulseCnt != '0)
      pulseCnt <= pulseCnt - CNT_ONE;
  end

  always_comb begin
    case (cfgMode)
      MODE_PULSE: intOut = (pulseCnt != '0);
      default:    intOut = pendingEnabled;
    endcase
  end

endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hubStrobe_t            strobe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_SRC-1:0]    wrData,
  input  logic [NUM_SRC-1:0]    evtIn,
  output logic [NUM_SRC-1:0]    rdData,
  output logic [NUM_SRC-1:0]    statusQ,
  output logic [NUM_SRC-1:0]    maskQ,
  output intMode_e              cfgMode,
  output logic                  cfgEnh,
  output logic                  newEnabled,
  output logic                  pendingEnabled
);

  logic [CFG_W-1:0]   cfgQ;
  logic [NUM_SRC-1:0] statusNext;

  assign cfgMode = intMode_e'(cfgQ[1:0]);
  assign cfgEnh  = cfgQ[2];

  // Per-source status cell: a set from an event beats any clear
  for (genvar b = 0; b < NUM_SRC; b++) begin : gStatCell
    logic setBit;
    assign setBit        = evtIn[b] & (cfgEnh | maskQ[b]);
    assign statusNext[b] = setBit | (statusQ[b] & ~strobe.clearStatus);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ <= '0;
    else if (strobe.loadMask) maskQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cfgQ <= CFG_RESET;
    else if (strobe.loadCfg) cfgQ <= wrData[CFG_W-1:0];
  end

  assign newEnabled     = |(evtIn & maskQ);
  assign pendingEnabled = |(statusQ & maskQ);

  always_comb begin
    case (regAddr)
      ADR_STATUS: rdData = statusQ;
      ADR_MASK:   rdData = maskQ;
      ADR_CFG:    rdData = NUM_SRC'(cfgQ);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  input  logic               swClear,
  output logic               intOut
);

  hubStrobe_t         strobe;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  intMode_e           cfgMode;
  logic               cfgEnh;
  logic               newEnabled;
  logic               pendingEnabled;

  irq_hub_ctrl #(.PULSE_LEN(PULSE_LEN)) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .rdEn           (rdEn),
    .regAddr        (regAddr),
    .swClear        (swClear),
    .cfgMode        (cfgMode),
    .newEnabled     (newEnabled),
    .pendingEnabled (pendingEnabled),
    .strobe         (strobe),
    .intOut         (intOut)
  );

  irq_hub_dp #(.NUM_SRC(NUM_SRC)) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .regAddr        (regAddr),
    .wrData         (wrData),
    .evtIn          (evtIn),
    .rdData         (rdData),
    .statusQ        (statusQ),
    .maskQ          (maskQ),
    .cfgMode        (cfgMode),
    .cfgEnh         (cfgEnh),
    .newEnabled     (newEnabled),
    .pendingEnabled (pendingEnabled)
  );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtIn,
  input logic               wrEn,
  input logic               rdEn,
  input logic [1:0]         regAddr,
  input logic               swClear,
  input logic               intOut,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input intMode_e           cfgMode,
  input logic               cfgEnh
);

  // R3: standard updating never latches a masked source
  assert_std_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnh |=> ((statusQ & ~$past(statusQ) & ~$past(maskQ)) == '0));

  // R4: enhanced updating latches every event
  assert_enh_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgEnh |=> (($past(evtIn) & ~statusQ) == '0));

  // R9: an eligible event survives a same-cycle clear
  assert_evt_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (swClear || rdEn) |=> (($past(evtIn) & ($past(cfgEnh) ? '1 : $past(maskQ)) & ~statusQ) == '0));

  // R6: a pulse only starts after an enabled event
  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgMode == MODE_PULSE) && $rose(intOut) && ($past(cfgMode) == MODE_PULSE))
      |-> $past(|(evtIn & maskQ)));

  // R7: a sticky level holds without a clear strobe or register write
  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (((cfgMode == MODE_LVL_SW) || (cfgMode == MODE_LVL_ALT)) && intOut && !swClear && !wrEn)
      |=> intOut);

  // R8: clear-on-read empties the status register
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgMode == MODE_LVL_AUTO) && rdEn && (regAddr == ADR_STATUS) && (evtIn == '0))
      |=> (statusQ == '0));

  // R10: software clear empties the status register
  assert_sw_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (swClear && (evtIn == '0)) |=> (statusQ == '0));

endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .evtIn   (evtIn),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .regAddr (regAddr),
  .swClear (swClear),
  .intOut  (intOut),
  .statusQ (statusQ),
  .maskQ   (maskQ),
  .cfgMode (cfgMode),
  .cfgEnh  (cfgEnh)
);

// File: tb/tb_irq_hub.sv
`timescale 1ns/100ps
module tb_irq_hub;
  localparam int N  = 16;
  localparam int PL = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] evtIn = '0;
  logic [N-1:0] wrData = '0;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic         swClear = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [N-1:0] rdData;
  logic         intOut;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  irq_hub #(.NUM_SRC(N), .PULSE_LEN(PL)) dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .rdEn(rdEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .swClear(swClear), .intOut(intOut)
  );

  task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1; tick(); wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [N-1:0] v);
    regAddr = a; #0.2; v = rdData;
  endtask

  task automatic fire(input logic [N-1:0] v);
    evtIn = v; tick(); evtIn = '0;
  endtask

  task automatic rdStat(output logic [N-1:0] v);
    regAddr = 2'd0; #0.2; v = rdData; rdEn = 1'b1; tick(); rdEn = 1'b0;
  endtask

  task automatic clr();
    swClear = 1'b1; tick(); swClear = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] one;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;

    // R1 reset state
    peek(2'd0, v); chk("R1", "status", v, '0);
    peek(2'd1, v); chk("R1", "mask", v, '0);
    peek(2'd2, v); chk("R1", "cfg", v, N'(1));
    chk("R1", "int", N'(intOut), '0);
    tick();

    // R2 register access
    wr(2'd1, 16'hA5C3); peek(2'd1, v); chk("R2", "mask rb", v, 16'hA5C3);
    wr(2'd2, 16'hFFF9); peek(2'd2, v); chk("R2", "cfg rb", v, 16'h0001);
    peek(2'd3, v); chk("R2", "spare sel", v, '0);
    wr(2'd1, '1); fire(16'h0003);
    wr(2'd0, 16'hFFFF); peek(2'd0, v); chk("R2", "status write ignored", v, 16'h0003);
    wr(2'd0, 16'h0000); peek(2'd0, v); chk("R2", "status write ignored", v, 16'h0003);
    clr();

    // R3 accumulation in standard updating
    fire(16'h0011); fire(16'h0100);
    peek(2'd0, v); chk("R3", "accumulate", v, 16'h0111);
    clr();

    // R3/R4/R5 sweep: every source, both mask polarities, both policies
    for (int enh = 0; enh < 2; enh++) begin
      wr(2'd2, N'(enh * 4 + 1));
      for (int m = 0; m < 2; m++) begin
        for (int b = 0; b < N; b++) begin
          one = N'(1) << b;
          clr();
          wr(2'd1, (m == 1) ? one : ~one);
          fire(one);
          peek(2'd0, v);
          chk((enh == 1) ? "R4" : "R3", $sformatf("status src %0d m%0d", b, m), v,
              ((enh == 1) || (m == 1)) ? one : '0);
          chk("R5", $sformatf("int src %0d m%0d enh%0d", b, m, enh), N'(intOut), N'(m));
        end
      end
    end

    // R5 late mask enable raises a latched enhanced bit
    clr(); wr(2'd1, '0); fire(16'h0040);
    chk("R5", "int masked", N'(intOut), '0);
    wr(2'd1, 16'h0040);
    chk("R5", "int after unmask", N'(intOut), N'(1));

    // R6 pulse mode
    clr(); wr(2'd2, 16'h0000); wr(2'd1, 16'hFFF7); tick(); tick(); tick(); tick(); tick();
    fire(16'h0002);
    for (int k = 0; k < 6; k++) begin
      chk("R6", $sformatf("pulse cycle %0d", k), N'(intOut), N'(k < PL));
      tick();
    end
    fire(16'h0004); tick(); tick();
    fire(16'h0004);
    for (int k = 0; k < 6; k++) begin
      chk("R6", $sformatf("retrigger cycle %0d", k), N'(intOut), N'(k < PL));
      tick();
    end
    wr(2'd2, 16'h0004);
    fire(16'h0008);
    for (int k = 0; k < 3; k++) begin
      chk("R6", $sformatf("masked no pulse %0d", k), N'(intOut), '0);
      tick();
    end

    // R7 sticky level survives reads (mode 1 and spare code 3)
    for (int md = 1; md < 4; md += 2) begin
      clr(); wr(2'd2, N'(md)); wr(2'd1, '1);
      fire(16'h0020);
      rdStat(v); chk("R7", "read value", v, 16'h0020);
      chk("R7", $sformatf("int after read mode %0d", md), N'(intOut), N'(1));
      peek(2'd0, v); chk("R7", "status kept", v, 16'h0020);
      clr();
      chk("R10", "int after clear", N'(intOut), '0);
      peek(2'd0, v); chk("R10", "status after clear", v, '0);
    end

    // R8 clear-on-read
    wr(2'd2, 16'h0002); fire(16'h0020);
    chk("R8", "int before read", N'(intOut), N'(1));
    rdStat(v); chk("R8", "read value", v, 16'h0020);
    chk("R8", "int after read", N'(intOut), '0);
    peek(2'd0, v); chk("R8", "status after read", v, '0);

    // R9 event beats clear-on-read
    fire(16'h0080);
    regAddr = 2'd0; evtIn = 16'h0200; rdEn = 1'b1; tick(); rdEn = 1'b0; evtIn = '0;
    peek(2'd0, v); chk("R9", "read+event", v, 16'h0200);
    chk("R9", "int kept", N'(intOut), N'(1));

    // R9 event beats software clear
    evtIn = 16'h0004; swClear = 1'b1; tick(); swClear = 1'b0; evtIn = '0;
    peek(2'd0, v); chk("R9", "clear+event", v, 16'h0004);

    // R10 clear in pulse mode empties status
    wr(2'd2, 16'h0000); fire(16'h1000); clr();
    peek(2'd0, v); chk("R10", "pulse mode clear", v, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule